// File: doc/BRIEF.md
# Dual-Port DAC Sample Formatter

This block turns half-rate sample pairs into a full-rate stream for a high-speed digital-to-analog converter. It runs on the full-rate clock. A source presents one 14-bit sample on port A and one on port B together with a one-cycle input strobe, at most once every two clock cycles. The block emits two full-rate samples per accepted pair. A one-hot mode select decides what those two samples are: both ports interleaved, port A repeated, port A followed by its negation, or port A followed by a zero sample. The last three are built-in 2x interpolation modes. Negation mixes the signal by half the output rate.

Samples use offset-binary code. All ones is full positive, all zeros is full negative, and midscale (`14'h2000` for the default width) is zero. Negation is the code reflected about midscale, which is a bitwise inversion of every bit. Mode select and sleep are sampled with each pair, so a change takes effect only on a pair boundary. The output carries a valid strobe, a flag that marks the first sample of each pair, and an error flag for pairs taken with a malformed mode select.

Top module: `dac_pair_formatter`

## Requirements
- R1: With mode select `4'b0001` (bit 0), a pair (a, b) is emitted as a then b.
- R2: With mode select `4'b0010` (bit 1), the pair is emitted as a then a, and port B has no effect on the output.
- R3: With mode select `4'b0100` (bit 2), the pair is emitted as a then the bitwise inverse of a, which is a reflected about midscale.
- R4: With mode select `4'b1000` (bit 3), the pair is emitted as a then the midscale code `1 << (DATA_W-1)`.
- R5: If the mode select is not exactly one-hot when a pair is accepted, that pair is emitted as in R1, and `fmtErr` is high on both of its output samples. `fmtErr` is low on every other cycle.
- R6: If `sleep` is high when a pair is accepted, both of its output samples are midscale and still carry `outValid`. A pair accepted after `sleep` drops is formatted normally from its first sample.
- R7: The first sample of a pair is on the output two clock cycles after the edge that accepts the pair, and the second sample follows one cycle later, in every mode.
- R8: `outFirst` is high exactly on the first sample of each pair. Every first sample is followed directly by the valid second sample of the same pair.
- R9: Out of reset, and on every cycle without a valid sample, `outValid`, `outFirst` and `fmtErr` are low and `outData` is midscale.
- R10: An input strobe on the cycle directly after an accepted strobe is dropped and produces no output samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pair strobe, one cycle per half-rate sample pair |
| portA | input | DATA_W | Port A sample, offset binary |
| portB | input | DATA_W | Port B sample, offset binary |
| modeSel | input | 4 | One-hot mode select: bit 0 interleave, bit 1 repeat, bit 2 negate, bit 3 zero-stuff |
| sleep | input | 1 | Forces the pair accepted with it to midscale |
| outData | output | DATA_W | Full-rate output sample |
| outValid | output | 1 | Output sample is valid |
| outFirst | output | 1 | Output sample is the first of its pair |
| fmtErr | output | 1 | Output sample belongs to a pair taken with a malformed mode select |

## Verification
The hardest situation to reach is a pair strobe that arrives on the cycle right after an accepted one, while the previous pair is still in flight. The bench drives two strobes back to back with different data. Only the first goes into the scoreboard, so any sample produced by the second one shows up as an unexpected output. The bench also sends pairs with no gap between them, and switches mode and sleep between consecutive pairs. This shows that a change in select lands cleanly on pair boundaries while output samples are flowing without a break.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;

  typedef enum logic [1:0] {
    FMT_PAIR   = 2'd0,
    FMT_REPEAT = 2'd1,
    FMT_NEGATE = 2'd2,
    FMT_ZSTUFF = 2'd3
  } fmtMode_e;

  typedef struct packed {
    logic     capture;
    logic     loadPair;
    logic     emitFirst;
    logic     emitSecond;
    fmtMode_e mode;
    logic     modeErr;
  } fmtStrobes_t;

endpackage

// File: rtl/dacfmt_ctrl.sv
module dacfmt_ctrl
  import dacfmt_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEL_W-1:0] modeSel,
  output fmtStrobes_t      strb
);

  logic     capV, pairV, secV;
  logic     accept;
  logic     selOneHot;
  fmtMode_e selMode;
  fmtMode_e capMode;
  logic     capErr;

  // A strobe right after an accepted one falls inside the same pair slot.
  assign accept    = inValid && !capV;
  assign selOneHot = (modeSel != '0) && ((modeSel & (modeSel - 1'b1)) == '0);

  always_comb begin
    selMode = FMT_PAIR;
    if (selOneHot) begin
      if (modeSel[1])      selMode = FMT_REPEAT;
      else if (modeSel[2]) selMode = FMT_NEGATE;
      else if (modeSel[3]) selMode = FMT_ZSTUFF;
      else                 selMode = FMT_PAIR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capV    <= 1'b0;
      pairV   <= 1'b0;
      secV    <= 1'b0;
      capMode <= FMT_PAIR;
      capErr  <= 1'b0;
    end else begin
      capV  <= accept;
      pairV <= capV;
      secV  <= pairV;
      if (accept) begin
        capMode <= selMode;
        capErr  <= !selOneHot;
      end
    end
  end

  always_comb begin
    strb.capture    = accept;
    strb.loadPair   = capV;
    strb.emitFirst  = pairV;
    strb.emitSecond = secV;
    strb.mode       = capMode;
    strb.modeErr    = capErr;
  end

  // R8
  no_emit_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.emitFirst && strb.emitSecond));

  // R7
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> ##1 strb.emitFirst);

  // R10
  drop_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !strb.capture);

endmodule

// File: rtl/dacfmt_datapath.sv
module dacfmt_datapath
  import dacfmt_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobes_t       strb,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  input  logic              sleepIn,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst,
  output logic              outErr
);

  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] capA, capB;
  logic              capSleep;
  logic [DATA_W-1:0] nextFirst, nextSecond;
  logic [DATA_W-1:0] pairFirst, pairSecond;
  logic              pairErr, pairSleep;
  fmtMode_e          pairMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capA     <= MID_CODE;
      capB     <= MID_CODE;
      capSleep <= 1'b0;
    end else if (strb.capture) begin
      capA     <= portA;
      capB     <= portB;
      capSleep <= sleepIn;
    end
  end

  always_comb begin
    nextFirst  = capA;
    nextSecond = capB;
    if (capSleep) begin
      nextFirst  = MID_CODE;
      nextSecond = MID_CODE;
    end else begin
      case (strb.mode)
        FMT_REPEAT: nextSecond = capA;
        FMT_NEGATE: nextSecond = ~capA;
        FMT_ZSTUFF: nextSecond = MID_CODE;
        default:    nextSecond = capB;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairFirst  <= MID_CODE;
      pairSecond <= MID_CODE;
      pairErr    <= 1'b0;
      pairSleep  <= 1'b0;
      pairMode   <= FMT_PAIR;
    end else if (strb.loadPair) begin
      pairFirst  <= nextFirst;
      pairSecond <= nextSecond;
      pairErr    <= strb.modeErr;
      pairSleep  <= capSleep;
      pairMode   <= strb.mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= MID_CODE;
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outErr   <= 1'b0;
    end else if (strb.emitFirst) begin
      outData  <= pairFirst;
      outValid <= 1'b1;
      outFirst <= 1'b1;
      outErr   <= pairErr;
    end else if (strb.emitSecond) begin
      outData  <= pairSecond;
      outValid <= 1'b1;
      outFirst <= 1'b0;
      outErr   <= pairErr;
    end else begin
      outData  <= MID_CODE;
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outErr   <= 1'b0;
    end
  end

  // R8
  pair_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirst) |=> (outValid && !outFirst));

  // R3
  negate_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitSecond && pairMode == FMT_NEGATE && !pairSleep)
      |=> (outData == ~$past(outData)));

  // R5
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> outValid);

  // R9
  idle_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == MID_CODE && !outFirst));

  // R6
  sleep_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitFirst && pairSleep) |=> (outData == MID_CODE && outValid));

endmodule

// File: rtl/dac_pair_formatter.sv
module dac_pair_formatter
  import dacfmt_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  input  logic [3:0]        modeSel,
  input  logic              sleep,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst,
  output logic              fmtErr
);

  fmtStrobes_t strb;

  dacfmt_ctrl #(.SEL_W(4)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .modeSel (modeSel),
    .strb    (strb)
  );

  dacfmt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .portA    (portA),
    .portB    (portB),
    .sleepIn  (sleep),
    .outData  (outData),
    .outValid (outValid),
    .outFirst (outFirst),
    .outErr   (fmtErr)
  );

endmodule

// File: tb/tb_dac_pair_formatter.sv
module tb_dac_pair_formatter;

  localparam int CLK_PERIOD = 10;
  localparam int W = 14;
  localparam logic [W-1:0] MID = 14'h2000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] portA = '0;
  logic [W-1:0] portB = '0;
  logic [3:0]   modeSel = 4'b0001;
  logic         sleep = 1'b0;
  logic [W-1:0] outData;
  logic         outValid, outFirst, fmtErr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit running = 1'b0;

  typedef struct {
    logic [W-1:0] data;
    logic         first;
    logic         err;
    int           when;
    string        req;
  } expItem_t;

  expItem_t sb[$];

  dac_pair_formatter #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .portA(portA), .portB(portB),
    .modeSel(modeSel), .sleep(sleep), .outData(outData), .outValid(outValid),
    .outFirst(outFirst), .fmtErr(fmtErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d, input logic f, input logic e,
                      input int when, input string req);
    expItem_t it;
    it.data = d; it.first = f; it.err = e; it.when = when; it.req = req;
    sb.push_back(it);
  endtask

  // Drive one pair at a negedge; it is accepted at the next posedge.
  task automatic sendPair(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [3:0] sel, input logic slp,
                          input logic [W-1:0] e1, input logic [W-1:0] e2,
                          input logic err, input string req, input int gap);
    int capCyc;
    @(negedge clk);
    portA = a; portB = b; modeSel = sel; sleep = slp; inValid = 1'b1;
    capCyc = cyc + 1;
    push(e1, 1'b1, err, capCyc + 2, req);
    push(e2, 1'b0, err, capCyc + 3, req);
    @(negedge clk);
    inValid = 1'b0;
    portB = ~b;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  // Monitor: pop and compare at each negedge once running.
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected sample", outData, 0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          check(outData == it.data, it.req, "data", outData, it.data);
          check(outFirst == it.first, "R8", "first flag", outFirst, it.first);
          check(fmtErr == it.err, "R5", "error flag", fmtErr, it.err);
          check(cyc == it.when, "R7", "latency cycle", cyc, it.when);
        end
      end else begin
        check(outData == MID && !outFirst && !fmtErr, "R9", "idle output",
              outData, MID);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outData == MID && !outValid && !outFirst && !fmtErr, "R9",
          "reset output", outData, MID);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;

    // R1 interleave, with gaps and back to back
    sendPair(14'h0123, 14'h3ABC, 4'b0001, 1'b0, 14'h0123, 14'h3ABC, 1'b0, "R1", 2);
    sendPair(14'h3FFF, 14'h0000, 4'b0001, 1'b0, 14'h3FFF, 14'h0000, 1'b0, "R1", 0);
    sendPair(14'h1555, 14'h2AAA, 4'b0001, 1'b0, 14'h1555, 14'h2AAA, 1'b0, "R1", 0);
    // R2 repeat ignores port B
    sendPair(14'h0A5A, 14'h3333, 4'b0010, 1'b0, 14'h0A5A, 14'h0A5A, 1'b0, "R2", 0);
    sendPair(14'h2001, 14'h0000, 4'b0010, 1'b0, 14'h2001, 14'h2001, 1'b0, "R2", 1);
    // R3 negate
    sendPair(14'h2000, 14'h1111, 4'b0100, 1'b0, 14'h2000, 14'h1FFF, 1'b0, "R3", 0);
    sendPair(14'h3FFF, 14'h1111, 4'b0100, 1'b0, 14'h3FFF, 14'h0000, 1'b0, "R3", 0);
    sendPair(14'h0F0F, 14'h1111, 4'b0100, 1'b0, 14'h0F0F, 14'h30F0, 1'b0, "R3", 2);
    // R4 zero-stuff
    sendPair(14'h3456, 14'h0001, 4'b1000, 1'b0, 14'h3456, MID, 1'b0, "R4", 0);
    sendPair(14'h0000, 14'h3FFF, 4'b1000, 1'b0, 14'h0000, MID, 1'b0, "R4", 1);
    // R5 malformed selects fall back to interleave
    sendPair(14'h0102, 14'h0304, 4'b0000, 1'b0, 14'h0102, 14'h0304, 1'b1, "R5", 0);
    sendPair(14'h0506, 14'h0708, 4'b0110, 1'b0, 14'h0506, 14'h0708, 1'b1, "R5", 0);
    sendPair(14'h090A, 14'h0B0C, 4'b1111, 1'b0, 14'h090A, 14'h0B0C, 1'b1, "R5", 0);
    sendPair(14'h0D0E, 14'h0F10, 4'b0100, 1'b0, 14'h0D0E, 14'h32F1, 1'b0, "R5", 1);
    // R6 sleep forces midscale, then resume on a pair boundary
    sendPair(14'h3ABC, 14'h0123, 4'b0001, 1'b1, MID, MID, 1'b0, "R6", 0);
    sendPair(14'h1234, 14'h0123, 4'b0100, 1'b1, MID, MID, 1'b0, "R6", 0);
    sendPair(14'h1234, 14'h2345, 4'b0001, 1'b0, 14'h1234, 14'h2345, 1'b0, "R6", 3);

    // R10 a strobe on the cycle after an accepted one is dropped
    begin
      int capCyc;
      @(negedge clk);
      portA = 14'h0AAA; portB = 14'h0BBB; modeSel = 4'b0001; sleep = 1'b0;
      inValid = 1'b1;
      capCyc = cyc + 1;
      push(14'h0AAA, 1'b1, 1'b0, capCyc + 2, "R10");
      push(14'h0BBB, 1'b0, 1'b0, capCyc + 3, "R10");
      @(negedge clk);
      portA = 14'h3CCC; portB = 14'h3DDD; modeSel = 4'b0010;
      @(negedge clk);
      inValid = 1'b0;
      repeat (4) @(negedge clk);
    end
    sendPair(14'h0777, 14'h0888, 4'b0001, 1'b0, 14'h0777, 14'h0888, 1'b0, "R10", 0);

    repeat (8) @(negedge clk);
    check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule